// File: doc/BRIEF.md
# Two-Phase CCD Readout Timing Generator

This block produces the digital phase clocks that read a full-frame, two-phase CCD. It drives two vertical phases (`vert_a`, `vert_b`), two horizontal phases (`horz_a`, `horz_b`) and the output-node reset gate (`node_rst`). Alongside them it gives a frame strobe, a line strobe and a per-pixel strobe that tells the downstream converter when to sample. All widths are counted in system-clock cycles. The pixel period, the vertical pulse width, the horizontal setup gap and the sample offset are input values. The block captures them only when a frame begins.

The block rests in the integrating state (`ST_INTEG`), where the vertical phases are parked low. A `start` pulse accepted there begins a readout of `N_LINES` lines. Each line passes through five states in a fixed order. `ST_VX_A` holds `vert_b` high for one vertical width. `ST_VX_B` holds `vert_a` high for one width; its falling edge moves the line into the horizontal register. `ST_VX_C` holds both phases low for one width. `ST_HSETUP` is the setup gap. `ST_HSHIFT` clocks `N_PIX` pixel periods out. From `ST_INTEG`, an accepted start moves to `ST_VX_A`. Each of the first four line states steps to the next one once its dwell count expires. `ST_HSHIFT` goes back to `ST_VX_A` after the last pixel of a line. After the last pixel of the last line it goes to `ST_INTEG`.

The reset gate pulses once in every pixel period in every state, including integration.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and whenever the block is integrating: `busy`=0, `vert_a`=`vert_b`=0, `horz_a`=0, `horz_b`=1, and `frame_strb`, `line_strb` and `adc_strb` are all low.
- R2: A `start` seen high at a clock edge while not busy begins a readout. `busy` then stays high for exactly `N_LINES` line periods and falls in the first cycle after them. A `start` seen while busy has no effect: it produces no extra strobe and does not alter any timing.
- R3: A line lasts 3·vpw + hsu + N_PIX·pix cycles. `line_strb` is high for the first cycle of each line. `frame_strb` is high together with the first line's `line_strb`, which is the cycle right after the accepting edge.
- R4: Each line starts with `vert_b` high for vpw cycles. `vert_a` is then high for vpw cycles. Both are then low for vpw cycles. `horz_b` stays high and `horz_a` stays low throughout the transfer and the setup gap. `vert_a` and `vert_b` are never high together.
- R5: In the shifting state, each pixel period starts with `horz_a` high for floor(pix/2) cycles, followed by `horz_b` high for the remaining cycles. `horz_a` and `horz_b` are always complementary.
- R6: `adc_strb` is high for one cycle per pixel, soff cycles after the falling edge of `horz_a` (at pixel phase floor(pix/2)+soff). It occurs only while shifting.
- R7: `node_rst` is high for `RST_W` cycles starting one cycle after the sample position, once in every pixel period and in every state, including integration. It is never high in the same cycle as `adc_strb` (the settings must satisfy floor(pix/2)+soff+RST_W < pix).
- R8: The four configuration inputs are captured only at an accepted start. Changing them during a readout has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a frame readout |
| cfg_pix | input | CW | Pixel period in cycles |
| cfg_vpw | input | CW | Vertical pulse width in cycles |
| cfg_hsu | input | CW | Horizontal setup gap in cycles |
| cfg_soff | input | CW | Sample delay after the horizontal phase-A fall |
| busy | output | 1 | Readout in progress |
| vert_a | output | 1 | Vertical phase A (line moves on its fall) |
| vert_b | output | 1 | Vertical phase B |
| horz_a | output | 1 | Horizontal phase A |
| horz_b | output | 1 | Horizontal phase B |
| node_rst | output | 1 | Output-node reset gate |
| frame_strb | output | 1 | One-cycle start-of-frame strobe |
| line_strb | output | 1 | One-cycle start-of-line strobe |
| adc_strb | output | 1 | One-cycle per-pixel sample strobe |

## Verification
The assertions check the following on every cycle:
- the vertical phases stay quiet while integrating;
- the two vertical phases never overlap;
- `vert_a` only rises straight after `vert_b`;
- `horz_b` is held high during vertical transfer;
- the horizontal phases stay complementary;
- the sample strobe never coincides with the reset gate;
- the frame strobe only follows an accepted start.

Only the bench scenarios can show exact cycle positions: the line period, the placement of each sample strobe, the reset-gate count over a window, capture of the configuration at frame start, and that a start issued mid-frame leaves the event timeline unchanged.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_INTEG  = 3'd0,
        ST_VX_A   = 3'd1,
        ST_VX_B   = 3'd2,
        ST_VX_C   = 3'd3,
        ST_HSETUP = 3'd4,
        ST_HSHIFT = 3'd5
    } seq_state_e;

endpackage

// File: rtl/ccd_step_cnt.sv
module ccd_step_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         last
);

    // A limit of 0 or 1 behaves as a single-step count.
    // The >= compare lets a shrunken limit wrap at once.
    assign last = (lim <= W'(1)) || (cnt >= lim - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= last ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/ccd_pix_shaper.sv
module ccd_pix_shaper #(
    parameter int CW    = 16,
    parameter int RST_W = 2
) (
    input  logic [CW-1:0] pc,
    input  logic [CW-1:0] pix,
    input  logic [CW-1:0] soff,
    input  logic          shifting,
    output logic          ha,
    output logic          hb,
    output logic          smp,
    output logic          rg
);

    logic [CW:0] half_w;
    logic [CW:0] spos;
    logic [CW:0] pc_w;

    always_comb begin
        half_w = {1'b0, pix >> 1};
        spos   = half_w + {1'b0, soff};
        pc_w   = {1'b0, pc};
        ha     = shifting && (pc_w < half_w);
        hb     = !ha;
        smp    = shifting && (pc_w == spos);
        rg     = (pc_w > spos) && (pc_w <= spos + (CW+1)'(RST_W));
    end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccd_seq_pkg::*;
#(
    parameter int N_LINES  = 1510,
    parameter int N_PIX    = 2267,
    parameter int CW       = 16,
    parameter int RST_W    = 2,
    parameter int DEF_PIX  = 25,
    parameter int DEF_VPW  = 1250,
    parameter int DEF_HSU  = 250,
    parameter int DEF_SOFF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_pix,
    input  logic [CW-1:0] cfg_vpw,
    input  logic [CW-1:0] cfg_hsu,
    input  logic [CW-1:0] cfg_soff,
    output logic          busy,
    output logic          vert_a,
    output logic          vert_b,
    output logic          horz_a,
    output logic          horz_b,
    output logic          node_rst,
    output logic          frame_strb,
    output logic          line_strb,
    output logic          adc_strb
);

    localparam int LW = $clog2(N_LINES + 1);
    localparam int PW = $clog2(N_PIX + 1);
    localparam logic [LW-1:0] LINE_LIM = LW'(N_LINES);
    localparam logic [PW-1:0] PIX_LIM  = PW'(N_PIX);

    seq_state_e state, state_nx;

    logic [CW-1:0] lat_pix, lat_vpw, lat_hsu, lat_soff;
    logic          accept;
    logic          shifting;
    logic          in_dwell;
    logic [CW-1:0] dwell_lim;

    logic [CW-1:0] pc,  dc;
    logic [PW-1:0] px;
    logic [LW-1:0] ln;
    logic          pc_last, dc_last, px_last, ln_last;

    logic          sh_ha, sh_hb, sh_smp, sh_rg;

    assign accept    = (state == ST_INTEG) && start;
    assign shifting  = (state == ST_HSHIFT);
    assign in_dwell  = (state == ST_VX_A) || (state == ST_VX_B) ||
                       (state == ST_VX_C) || (state == ST_HSETUP);
    assign dwell_lim = (state == ST_HSETUP) ? lat_hsu : lat_vpw;

    // Configuration capture: only on an accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_pix  <= CW'(DEF_PIX);
            lat_vpw  <= CW'(DEF_VPW);
            lat_hsu  <= CW'(DEF_HSU);
            lat_soff <= CW'(DEF_SOFF);
        end else if (accept) begin
            lat_pix  <= cfg_pix;
            lat_vpw  <= cfg_vpw;
            lat_hsu  <= cfg_hsu;
            lat_soff <= cfg_soff;
        end
    end

    // Pixel phase: free running, realigned on entry to shifting.
    ccd_step_cnt #(.W(CW)) u_pix_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  ((state == ST_HSETUP) && dc_last),
        .en   (1'b1),
        .lim  (lat_pix),
        .cnt  (pc),
        .last (pc_last)
    );

    // Dwell time of the transfer and setup states.
    ccd_step_cnt #(.W(CW)) u_dwell (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != state_nx),
        .en   (in_dwell),
        .lim  (dwell_lim),
        .cnt  (dc),
        .last (dc_last)
    );

    // Pixel index within a line.
    ccd_step_cnt #(.W(PW)) u_pix_idx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!shifting),
        .en   (shifting && pc_last),
        .lim  (PIX_LIM),
        .cnt  (px),
        .last (px_last)
    );

    // Line index within a frame.
    ccd_step_cnt #(.W(LW)) u_line_idx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (shifting && pc_last && px_last),
        .lim  (LINE_LIM),
        .cnt  (ln),
        .last (ln_last)
    );

    ccd_pix_shaper #(.CW(CW), .RST_W(RST_W)) u_shaper (
        .pc      (pc),
        .pix     (lat_pix),
        .soff    (lat_soff),
        .shifting(shifting),
        .ha      (sh_ha),
        .hb      (sh_hb),
        .smp     (sh_smp),
        .rg      (sh_rg)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INTEG;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INTEG:  if (start)   state_nx = ST_VX_A;
            ST_VX_A:   if (dc_last) state_nx = ST_VX_B;
            ST_VX_B:   if (dc_last) state_nx = ST_VX_C;
            ST_VX_C:   if (dc_last) state_nx = ST_HSETUP;
            ST_HSETUP: if (dc_last) state_nx = ST_HSHIFT;
            ST_HSHIFT: if (pc_last && px_last)
                           state_nx = ln_last ? ST_INTEG : ST_VX_A;
            default:   state_nx = ST_INTEG;
        endcase
    end

    // Outputs.
    always_comb begin
        busy       = (state != ST_INTEG);
        vert_a     = 1'b0;
        vert_b     = 1'b0;
        horz_a     = 1'b0;
        horz_b     = 1'b1;
        node_rst   = sh_rg;
        frame_strb = 1'b0;
        line_strb  = 1'b0;
        adc_strb   = 1'b0;
        unique case (state)
            ST_INTEG: ;
            ST_VX_A: begin
                vert_b     = 1'b1;
                line_strb  = (dc == '0);
                frame_strb = (dc == '0) && (ln == '0);
            end
            ST_VX_B: vert_a = 1'b1;
            ST_VX_C: ;
            ST_HSETUP: ;
            ST_HSHIFT: begin
                horz_a   = sh_ha;
                horz_b   = sh_hb;
                adc_strb = sh_smp;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic vert_a,
    input logic vert_b,
    input logic horz_a,
    input logic horz_b,
    input logic node_rst,
    input logic frame_strb,
    input logic line_strb,
    input logic adc_strb
);

    p_integ_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!vert_a && !vert_b && !adc_strb && !line_strb && !frame_strb));

    p_frame_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strb |-> ($past(start) && !$past(busy)));

    p_frame_with_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strb |-> (line_strb && busy));

    p_vert_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vert_a && vert_b));

    p_vert_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vert_a) |-> $past(vert_b));

    p_hold_during_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vert_a || vert_b) |-> (horz_b && !horz_a));

    p_horz_comp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        horz_a != horz_b);

    p_sample_in_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strb |-> (horz_b && busy));

    p_sample_not_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strb |-> !node_rst);

endmodule

bind ccd_readout_seq ccd_readout_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .vert_a    (vert_a),
    .vert_b    (vert_b),
    .horz_a    (horz_a),
    .horz_b    (horz_b),
    .node_rst  (node_rst),
    .frame_strb(frame_strb),
    .line_strb (line_strb),
    .adc_strb  (adc_strb)
);

// File: tb/ccd_readout_seq_tb_top.sv
`timescale 1ns/1ps
module ccd_readout_seq_tb_top;

    localparam int N_LINES = 3;
    localparam int N_PIX   = 5;
    localparam int CW      = 16;
    localparam int RST_W   = 2;

    localparam int EV_SOF  = 0;
    localparam int EV_SOL  = 1;
    localparam int EV_V2R  = 2;
    localparam int EV_VF   = 3;
    localparam int EV_SMP  = 4;
    localparam int EV_IDLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] cfg_pix = 16'd8, cfg_vpw = 16'd3, cfg_hsu = 16'd4, cfg_soff = 16'd1;
    logic busy, vert_a, vert_b, horz_a, horz_b, node_rst, frame_strb, line_strb, adc_strb;

    int     total = 0;
    int     bad = 0;
    longint cyc = 0;
    bit     finished = 0;
    int     q_kind[$];
    longint q_time[$];
    logic   va_d = 0, vb_d = 0, busy_d = 0;
    int     ha_cnt = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ccd_readout_seq #(
        .N_LINES(N_LINES), .N_PIX(N_PIX), .CW(CW), .RST_W(RST_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_pix(cfg_pix), .cfg_vpw(cfg_vpw), .cfg_hsu(cfg_hsu), .cfg_soff(cfg_soff),
        .busy(busy), .vert_a(vert_a), .vert_b(vert_b), .horz_a(horz_a), .horz_b(horz_b),
        .node_rst(node_rst), .frame_strb(frame_strb), .line_strb(line_strb), .adc_strb(adc_strb)
    );

    function automatic string ev_req(int k);
        case (k)
            EV_SOF:  return "R3 frame strobe";
            EV_SOL:  return "R3 line strobe";
            EV_V2R:  return "R4 vert_b rise";
            EV_VF:   return "R4 vert_a fall";
            EV_SMP:  return "R6 sample strobe";
            default: return "R2 busy fall";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic got_event(input int k);
        if (q_kind.size() == 0) begin
            chk(0, {ev_req(k), " unexpected"}, cyc, -1);
        end else begin
            int     ek = q_kind.pop_front();
            longint et = q_time.pop_front();
            chk(ek == k && et == cyc, ev_req(ek), cyc, et);
        end
    endtask

    // Monitor: compares observed events with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (frame_strb)        got_event(EV_SOF);
            if (line_strb)         got_event(EV_SOL);
            if (vert_b && !vb_d)   got_event(EV_V2R);
            if (!vert_a && va_d)   got_event(EV_VF);
            if (adc_strb)          got_event(EV_SMP);
            if (!busy && busy_d)   got_event(EV_IDLE);
            if (busy && horz_a)    ha_cnt++;
            va_d   <= vert_a;
            vb_d   <= vert_b;
            busy_d <= busy;
        end
    end

    // Driver: loads configuration, predicts the event timeline, issues start.
    task automatic run_frame(input int pix, input int vpw, input int hsu, input int soff,
                             input bit poke_mid);
        longint base, tl, ls, s;
        int     half;
        @(negedge clk);
        cfg_pix = CW'(pix); cfg_vpw = CW'(vpw); cfg_hsu = CW'(hsu); cfg_soff = CW'(soff);
        half = pix / 2;
        tl   = 3*vpw + hsu + N_PIX*pix;
        base = cyc + 1;
        ha_cnt = 0;
        for (int l = 0; l < N_LINES; l++) begin
            ls = base + l*tl;
            if (l == 0) begin q_kind.push_back(EV_SOF); q_time.push_back(ls); end
            q_kind.push_back(EV_SOL); q_time.push_back(ls);
            q_kind.push_back(EV_V2R); q_time.push_back(ls);
            q_kind.push_back(EV_VF);  q_time.push_back(ls + 2*vpw);
            s = ls + 3*vpw + hsu;
            for (int k = 0; k < N_PIX; k++) begin
                q_kind.push_back(EV_SMP); q_time.push_back(s + k*pix + half + soff);
            end
        end
        q_kind.push_back(EV_IDLE); q_time.push_back(base + N_LINES*tl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            // R8: new values mid-frame; R2: start while busy is ignored
            cfg_pix = 16'd4; cfg_vpw = 16'd1; cfg_hsu = 16'd1; cfg_soff = 16'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R2 busy kept after ignored start", busy, 1);
        end
        while (busy || q_kind.size() != 0) @(negedge clk);
        chk(ha_cnt == N_LINES*N_PIX*half, "R5 horz_a high cycles", ha_cnt, N_LINES*N_PIX*half);
        chk(vert_a == 0 && vert_b == 0 && horz_b == 1, "R1 parked after frame",
            {vert_a, vert_b, horz_b}, 3'b001);
    endtask

    task automatic idle_reset_count(input int pix);
        int n = 0;
        for (int i = 0; i < 10*pix; i++) begin
            @(negedge clk);
            if (node_rst) n++;
        end
        chk(n == 10*RST_W, "R7 reset gate pulses while integrating", n, 10*RST_W);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(vert_a == 0 && vert_b == 0, "R1 vertical low", {vert_a, vert_b}, 0);
        chk(horz_a == 0 && horz_b == 1, "R1 horizontal parked", {horz_a, horz_b}, 2'b01);
        chk(!frame_strb && !line_strb && !adc_strb, "R1 strobes low",
            {frame_strb, line_strb, adc_strb}, 0);
        idle_reset_count(25);
        run_frame(8, 3, 4, 1, 1'b1);
        idle_reset_count(8);
        run_frame(6, 1, 1, 0, 1'b0);
        run_frame(7, 2, 3, 1, 1'b0);
        idle_reset_count(7);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule